// File: doc/BRIEF.md
# Shared-Write Slice Memory

This block gathers four small RAM cells into one slice-level memory whose write side is common to every cell: the same write enable, write address and write data reach each of them on a single clock. Only the read addresses differ from cell to cell. A mode parameter decides how the cells are arranged. Three arrangements are available: a 32-entry by 2-bit memory with four read ports, a 32-entry by 6-bit simple dual-port memory, and a 128-entry by 1-bit memory.

The first cell has no read address of its own. Its read address is tied to the write address, so in the four-port arrangement read port 0 always shows the word at the address currently being written. In the wide arrangement that cell is left out, and three cells each hold one 2-bit slice of the 6-bit word. In the deep arrangement two 64-entry by 1-bit cells each hold one half of the address space. The top write-address bit gates the write enable of each cell, and the top read-address bit selects which cell output is read. All reads are combinational. The contents start from an initial pattern parameter, which is all zeros by default.

Top module: `slice_shared_ram`

## Requirements
- R1: In quad mode (MODE_QUAD), a rising clock edge with `we` high stores `wdata[1:0]` at the 5-bit `waddr` in all four cells.
- R2: In quad mode, `rdata[0]` always shows the stored word at the current `waddr`, whatever the read addresses are.
- R3: In quad mode, `rdata[k]` for k = 1, 2, 3 shows the stored word at `raddr[k-1]`, and each port is independent of the others.
- R4: In quad mode, two read ports given the same address show the same data, because all cells hold identical contents.
- R5: In wide mode (MODE_WIDE), `wdata[5:0]` is written at the 5-bit `waddr`, and `rdata[0][5:0]` shows the full 6-bit word at `raddr[0]`.
- R6: In deep mode (MODE_DEEP), `waddr[6]` chooses which of the two 64-entry halves is written. The entry with the same low six address bits in the other half keeps its value.
- R7: In deep mode, `rdata[0][0]` shows the bit at the 7-bit `raddr[0]`, with `raddr[0][6]` selecting the half.
- R8: In every mode, a clock edge with `we` low changes no stored entry.
- R9: Reads are combinational. A changed read address shows its new data in the same cycle, and a written value appears only after the clock edge that writes it.
- R10: With the default initial pattern, every entry reads as zero before the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| we | input | 1 | Write enable, sampled on the rising edge |
| waddr | input | AW (5, or 7 in deep mode) | Write address, shared by all cells |
| wdata | input | DW (2 quad, 6 wide, 1 deep) | Write data, shared by all cells |
| raddr | input | NRA x AW (NRA = 3 in quad mode, else 1) | Independent read addresses |
| rdata | output | NRD x DW (NRD = 4 in quad mode, else 1) | Combinational read data; in quad mode entry 0 follows `waddr` |

## Verification
Any wrong stored bit reaches the ports in the same cycle that a read port points at its address, because reads pass through no register. Quad mode shows a cell that missed a shared write right away: it disagrees with port 0 or with a sibling port at equal addresses. In deep mode, a bad write steer or a bad read select shows as corruption of the other half at the mirrored address on the next read. Random writes and reads per mode are compared with bench models. Directed cases add write-then-read, disabled writes and mirrored deep addresses.

// File: rtl/slram_pkg.sv
package slram_pkg;

   typedef enum logic [1:0] {
      MODE_QUAD = 2'd0,
      MODE_WIDE = 2'd1,
      MODE_DEEP = 2'd2
   } slice_mode_e;

   localparam int CELL_ABITS = 6;
   localparam int CELL_DEPTH = 1 << CELL_ABITS;
   localparam int NUM_CELLS  = 4;

   function automatic int addr_bits(slice_mode_e m);
      return (m == MODE_DEEP) ? CELL_ABITS + 1 : CELL_ABITS - 1;
   endfunction

   function automatic int data_bits(slice_mode_e m);
      case (m)
         MODE_QUAD: return 2;
         MODE_WIDE: return 2 * (NUM_CELLS - 1);
         default:   return 1;
      endcase
   endfunction

   function automatic int read_addr_count(slice_mode_e m);
      return (m == MODE_QUAD) ? NUM_CELLS - 1 : 1;
   endfunction

   function automatic int read_port_count(slice_mode_e m);
      return (m == MODE_QUAD) ? NUM_CELLS : 1;
   endfunction

endpackage

// File: rtl/ram_cell.sv
module ram_cell #(
   parameter int                              BITS = 2,
   parameter bit                              TIED = 1'b0,
   parameter logic [slram_pkg::CELL_DEPTH-1:0] INIT = '0
) (
   input  logic                            clk,
   input  logic                            we,
   input  logic [slram_pkg::CELL_ABITS-1:0] wa,
   input  logic [BITS-1:0]                  wd,
   input  logic [slram_pkg::CELL_ABITS-1:0] ra,
   output logic [BITS-1:0]                  rq
);
   localparam int AB    = slram_pkg::CELL_ABITS;
   localparam int DEPTH = slram_pkg::CELL_DEPTH;

   if (BITS != 1 && BITS != 2) begin : g_bad_bits
      $error("ram_cell: BITS must be 1 or 2");
   end

   logic [DEPTH-1:0] mem = INIT;
   logic [AB-1:0]    ra_eff;

   assign ra_eff = TIED ? wa : ra;

   if (BITS == 2) begin : g_pair
      logic [AB-1:0] wa_hi, ra_hi;
      assign wa_hi = {~wa[AB-1], wa[AB-2:0]};
      assign ra_hi = {~ra_eff[AB-1], ra_eff[AB-2:0]};
      always_ff @(posedge clk) begin
         if (we) begin
            mem[wa]    <= wd[0];
            mem[wa_hi] <= wd[1];
         end
      end
      assign rq = {mem[ra_hi], mem[ra_eff]};
   end else begin : g_single
      always_ff @(posedge clk) begin
         if (we) mem[wa] <= wd[0];
      end
      assign rq = mem[ra_eff];
   end
endmodule

// File: rtl/half_select.sv
module half_select #(
   parameter int W = 1
) (
   input  logic         sel,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] y
);
   always_comb begin
      y = sel ? hi : lo;
   end
endmodule

// File: rtl/slice_shared_ram.sv
module slice_shared_ram
   import slram_pkg::*;
#(
   parameter slice_mode_e             MODE = MODE_QUAD,
   parameter logic [CELL_DEPTH-1:0]   INIT = '0,
   localparam int AW  = addr_bits(MODE),
   localparam int DW  = data_bits(MODE),
   localparam int NRA = read_addr_count(MODE),
   localparam int NRD = read_port_count(MODE)
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRA-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);
   localparam int AB = CELL_ABITS;

   if (MODE != MODE_QUAD && MODE != MODE_WIDE && MODE != MODE_DEEP) begin : g_bad_mode
      $error("slice_shared_ram: unknown MODE");
   end
   if (NUM_CELLS != 4) begin : g_bad_cells
      $error("slice_shared_ram: arrangement assumes four cells");
   end

   logic [AW-1:0] chk_addr;

   if (MODE == MODE_QUAD) begin : g_quad
      for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
         logic [AB-1:0] cra;
         if (i == 0) begin : g_tied
            assign cra = '0;
         end else begin : g_free
            assign cra = {1'b0, raddr[i-1]};
         end
         ram_cell #(.BITS(2), .TIED(i == 0), .INIT(INIT)) u_cell (
            .clk (clk),
            .we  (we),
            .wa  ({1'b0, waddr}),
            .wd  (wdata),
            .ra  (cra),
            .rq  (rdata[i])
         );
      end
      assign chk_addr = waddr;

      always_ff @(posedge clk) begin
         for (int k = 1; k < NUM_CELLS; k++) begin
            if (raddr[k-1] == waddr) begin
               assert_ports_agree_R4: assert (rdata[k] == rdata[0])
                  else $error("R4: port %0d disagrees with port 0", k);
            end
         end
      end
   end else if (MODE == MODE_WIDE) begin : g_wide
      for (genvar i = 1; i < NUM_CELLS; i++) begin : g_cell
         logic [1:0] cq;
         ram_cell #(.BITS(2), .TIED(1'b0), .INIT(INIT)) u_cell (
            .clk (clk),
            .we  (we),
            .wa  ({1'b0, waddr}),
            .wd  (wdata[2*i-2 +: 2]),
            .ra  ({1'b0, raddr[0]}),
            .rq  (cq)
         );
         assign rdata[0][2*i-2 +: 2] = cq;
      end
      assign chk_addr = raddr[0];
   end else begin : g_deep
      logic [1:0] half_we;
      logic [1:0] half_q;
      for (genvar h = 0; h < 2; h++) begin : g_half
         assign half_we[h] = we & (waddr[AW-1] == h[0]);
         ram_cell #(.BITS(1), .TIED(1'b0), .INIT(INIT)) u_cell (
            .clk (clk),
            .we  (half_we[h]),
            .wa  (waddr[AB-1:0]),
            .wd  (wdata),
            .ra  (raddr[0][AB-1:0]),
            .rq  (half_q[h])
         );
      end
      half_select #(.W(1)) u_sel (
         .sel (raddr[0][AW-1]),
         .lo  (half_q[0]),
         .hi  (half_q[1]),
         .y   (rdata[0])
      );
      assign chk_addr = raddr[0];

      always_ff @(posedge clk) begin
         assert_one_half_written_R6: assert ($onehot0(half_we))
            else $error("R6: both halves write-enabled");
      end
   end

   // Checker state: what the primary read port showed one cycle earlier.
   logic          prev_ok   = 1'b0;
   logic          prev_we   = 1'b0;
   logic [AW-1:0] prev_wa   = '0;
   logic [AW-1:0] prev_ra   = '0;
   logic [DW-1:0] prev_wd   = '0;
   logic [DW-1:0] prev_q    = '0;

   always_ff @(posedge clk) begin
      if (prev_ok && prev_we && chk_addr == prev_wa) begin
         assert_write_then_read_R9: assert (rdata[0] == prev_wd)
            else $error("R9: written word not visible after edge");
      end
      if (prev_ok && chk_addr == prev_ra && !(prev_we && prev_wa == prev_ra)) begin
         assert_unwritten_holds_R8: assert (rdata[0] == prev_q)
            else $error("R8: unwritten entry changed");
      end
      prev_ok <= 1'b1;
      prev_we <= we;
      prev_wa <= waddr;
      prev_ra <= chk_addr;
      prev_wd <= wdata;
      prev_q  <= rdata[0];
   end
endmodule

// File: tb/tb_slice_shared_ram.sv
module tb_slice_shared_ram;
   import slram_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   // quad
   logic            q_we = 0;
   logic [4:0]      q_wa = '0;
   logic [1:0]      q_wd = '0;
   logic [2:0][4:0] q_ra = '0;
   logic [3:0][1:0] q_rd;
   // wide
   logic            w_we = 0;
   logic [4:0]      w_wa = '0;
   logic [5:0]      w_wd = '0;
   logic [0:0][4:0] w_ra = '0;
   logic [0:0][5:0] w_rd;
   // deep
   logic            d_we = 0;
   logic [6:0]      d_wa = '0;
   logic [0:0]      d_wd = '0;
   logic [0:0][6:0] d_ra = '0;
   logic [0:0][0:0] d_rd;

   slice_shared_ram #(.MODE(MODE_QUAD)) dut (
      .clk(clk), .we(q_we), .waddr(q_wa), .wdata(q_wd), .raddr(q_ra), .rdata(q_rd));
   slice_shared_ram #(.MODE(MODE_WIDE)) dut_wide (
      .clk(clk), .we(w_we), .waddr(w_wa), .wdata(w_wd), .raddr(w_ra), .rdata(w_rd));
   slice_shared_ram #(.MODE(MODE_DEEP)) dut_deep (
      .clk(clk), .we(d_we), .waddr(d_wa), .wdata(d_wd), .raddr(d_ra), .rdata(d_rd));

   logic [1:0] mq [32];
   logic [5:0] mw [32];
   logic       md [128];

   function automatic logic [1:0] exp_q(input logic [4:0] a);
      return mq[a];
   endfunction
   function automatic logic [5:0] exp_w(input logic [4:0] a);
      return mw[a];
   endfunction
   function automatic logic exp_d(input logic [6:0] a);
      return md[a];
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_quad(input string tag);
      chk({tag, " R2 port0"}, int'(q_rd[0]), int'(exp_q(q_wa)));
      for (int k = 1; k < 4; k++)
         chk({tag, " R3 portk"}, int'(q_rd[k]), int'(exp_q(q_ra[k-1])));
   endtask

   task automatic quad_cycle(input logic we_i, input logic [4:0] wa, input logic [1:0] wd,
                             input logic [4:0] a1, input logic [4:0] a2, input logic [4:0] a3);
      @(negedge clk);
      q_we = we_i; q_wa = wa; q_wd = wd;
      q_ra[0] = a1; q_ra[1] = a2; q_ra[2] = a3;
      #2 chk_quad("quad R1");
      @(posedge clk);
      if (we_i) mq[wa] = wd;
   endtask

   task automatic wide_cycle(input logic we_i, input logic [4:0] wa, input logic [5:0] wd,
                             input logic [4:0] ra);
      @(negedge clk);
      w_we = we_i; w_wa = wa; w_wd = wd; w_ra[0] = ra;
      #2 chk("wide R5", int'(w_rd[0]), int'(exp_w(ra)));
      @(posedge clk);
      if (we_i) mw[wa] = wd;
   endtask

   task automatic deep_cycle(input logic we_i, input logic [6:0] wa, input logic wd,
                             input logic [6:0] ra);
      @(negedge clk);
      d_we = we_i; d_wa = wa; d_wd = wd; d_ra[0] = ra;
      #2 chk("deep R6 R7", int'(d_rd[0]), int'(exp_d(ra)));
      @(posedge clk);
      if (we_i) md[wa] = wd;
   endtask

   initial begin
      void'($urandom(32'd2024));
      foreach (mq[i]) mq[i] = '0;
      foreach (mw[i]) mw[i] = '0;
      foreach (md[i]) md[i] = 1'b0;

      // R10: initial contents are zero
      @(negedge clk); #2;
      q_ra[0] = 5'd7; q_ra[1] = 5'd31; q_ra[2] = 5'd0; w_ra[0] = 5'd19; d_ra[0] = 7'd100;
      #1;
      chk("R10 quad", int'(q_rd), 0);
      chk("R10 wide", int'(w_rd[0]), 0);
      chk("R10 deep", int'(d_rd[0]), 0);

      // R9: write at 9 while port 1 reads 9: old before edge, new after
      @(negedge clk);
      q_we = 1; q_wa = 5'd9; q_wd = 2'b10; q_ra[0] = 5'd9; q_ra[1] = 5'd3; q_ra[2] = 5'd9;
      #2 chk("R9 before edge", int'(q_rd[1]), 0);
      chk("R9 port0 before edge", int'(q_rd[0]), 0);
      @(posedge clk); mq[9] = 2'b10;
      @(negedge clk); q_we = 0; #2;
      chk("R9 after edge", int'(q_rd[1]), 2);
      chk("R4 ports agree", int'(q_rd[3]), int'(q_rd[1]));
      chk("R2 port0 follows waddr", int'(q_rd[0]), 2);
      q_ra[0] = 5'd3; #1;
      chk("R9 address change same cycle", int'(q_rd[1]), 0);

      // R8: disabled write leaves entry
      @(negedge clk); q_we = 0; q_wa = 5'd9; q_wd = 2'b01;
      @(posedge clk);
      @(negedge clk); q_ra[0] = 5'd9; #2;
      chk("R8 quad we low", int'(q_rd[1]), 2);

      // R5 directed
      wide_cycle(1, 5'd4, 6'b101101, 5'd4);
      wide_cycle(0, 5'd4, 6'b010010, 5'd4);
      wide_cycle(0, 5'd0, 6'b0, 5'd4);
      chk("R5 wide word", int'(w_rd[0]), 6'h2d);
      chk("R8 wide we low", int'(w_rd[0]), int'(mw[4]));

      // R6/R7 directed: mirrored addresses in the two halves
      deep_cycle(1, 7'd5, 1'b1, 7'd5);
      deep_cycle(1, 7'd69, 1'b0, 7'd69);
      deep_cycle(0, 7'd69, 1'b1, 7'd5);
      chk("R6 low half kept", int'(d_rd[0]), 1);
      deep_cycle(1, 7'd70, 1'b1, 7'd6);
      deep_cycle(0, 7'd0, 1'b0, 7'd6);
      chk("R6 other half untouched", int'(d_rd[0]), 0);
      d_ra[0] = 7'd70; #1;
      chk("R7 high half select", int'(d_rd[0]), 1);

      // Random phases
      for (int n = 0; n < 400; n++)
         quad_cycle(1'($urandom), 5'($urandom), 2'($urandom),
                    5'($urandom), 5'($urandom), 5'($urandom));
      for (int n = 0; n < 300; n++)
         wide_cycle(1'($urandom), 5'($urandom), 6'($urandom), 5'($urandom));
      for (int n = 0; n < 600; n++)
         deep_cycle(1'($urandom), 7'($urandom), 1'($urandom), 7'($urandom));

      // R4: all ports same address
      quad_cycle(0, 5'd12, 2'b0, 5'd12, 5'd12, 5'd12);
      @(negedge clk); #2;
      chk("R4 equal addresses", int'(q_rd[2]), int'(q_rd[1]));
      chk("R4 equal addresses port3", int'(q_rd[3]), int'(q_rd[0]));

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule